// File: doc/BRIEF.md
# Double-Buffered PWM Timebase with Scheduled Reload

This block is a single PWM timebase whose prescaler, period and duty settings are double-buffered. Software writes new settings into holding registers through a small register port. It then arms a load flag. The working copies that drive the counter change only when a reload point arrives.

A reload point is picked by a divider that counts reload opportunities. The divider is programmable from one to sixteen opportunities. In up-only (edge-aligned) mode an opportunity is the wrap of the counter. In up/down (center-aligned) mode an opportunity is the return to zero. Center-aligned mode can optionally add a second opportunity at the top of the count.

The outputs are the live count, a PWM level that is high while the count is below the working duty value, a one-cycle reload strobe and the state of the load flag. Typical use is to compute new settings, write them, arm, and then wait for the flag to drop before writing the next set.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: After reset the count is 0, the load flag is 0, the strobe and the PWM output are low, the control word (address 0) reads 0 and the modulus holding register (address 1) reads 16.
- R2: At a reload point the load flag, if set, is cleared, and the held prescaler select, modulus (address 1) and duty value (address 2) become the working values from that point on.
- R3: The load flag is set only by writing 1 to bit 0 of address 3 when the previous access to address 3 was a read that returned bit 0 as 0. Any write to address 3 uses up that permission.
- R4: The prescaler select is control bits [1:0]. Each count value lasts 2^select clocks, and the prescaler restarts at every reload point.
- R5: With control bit 7 clear (edge-aligned), the count runs 0 to M-1 and wraps. The PWM output is high for V*2^select clocks of each M*2^select-clock period.
- R6: With control bit 7 set (center-aligned, M of at least 2), the count runs 0 up to M and back down to 1, then returns to 0. A period is 2*M*2^select clocks, and for 1 <= V <= M the output is high for (2V-1)*2^select of them.
- R7: Control bits [5:2] hold L. A reload point occurs on every (L+1)th opportunity, and the strobe is high for one clock at each reload point. The divider keeps counting when the load flag is clear; such a reload point leaves the working values unchanged.
- R8: The opportunity divider starts from zero at reset. With L = 3 and the reset modulus of 16, the first strobe shows 64 clocks after reset is released.
- R9: In center-aligned mode with control bit 6 set, the top of the count (count equal to M) is also an opportunity. A reload of a new modulus there moves the count to the new M-1 on the next clock.
- R10: In edge-aligned mode control bit 6 has no effect on the reload rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 modulus, 2 duty, 3 load flag |
| reg_wdata | input | DW (16) | Write data |
| reg_rdata | output | DW (16) | Read data, combinational from reg_addr |
| count | output | CW (8) | Live counter value |
| pwm_out | output | 1 | PWM level: high while count is below the working duty value |
| reload_strobe | output | 1 | One-clock pulse at each reload point |
| load_ok | output | 1 | Load flag |

## Verification
Each result has a fixed latency. A register write takes effect on the next clock and read data is available in the same cycle. The strobe, the cleared load flag and the new working values all appear together one clock after the opportunity in which the reload point falls. The PWM output follows the count with no added delay.

The bench drives inputs and samples outputs on falling edges, so every check reads state that has settled after the rising edge before it. Period and duty are measured as the clock count from one strobe to the next and the number of high PWM clocks in that span. Both figures are independent of phase and are compared with closed-form products of M, V, L and the prescaler. The half-cycle snap is checked on the first sample after the strobe, against the count observed one sample earlier.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;

   localparam int PSC_W = 2;   // prescaler select width
   localparam int LDF_W = 4;   // reload divider field width

   typedef struct packed {
      logic             center;  // bit 7: up/down counting
      logic             half;    // bit 6: extra opportunity at the top
      logic [LDF_W-1:0] ldiv;    // bits 5:2: reload every ldiv+1 opportunities
      logic [PSC_W-1:0] psc;     // bits 1:0: prescaler select (buffered)
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   typedef enum logic [1:0] {
      RA_CTRL = 2'd0,
      RA_MOD  = 2'd1,
      RA_DUTY = 2'd2,
      RA_ARM  = 2'd3
   } reg_addr_e;

endpackage

// File: rtl/pwm_reg_bank.sv
module pwm_reg_bank
   import pwm_reload_pkg::*;
#(
   parameter int DW      = 16,
   parameter int CW      = 8,
   parameter int RST_MOD = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             rd,
   input  logic [1:0]       addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   input  logic             reload_pt,
   output ctrl_t            ctrl,
   output logic [CW-1:0]    held_mod,
   output logic [PSC_W-1:0] work_psc,
   output logic [CW-1:0]    work_mod,
   output logic [CW-1:0]    work_duty,
   output logic             armed,
   output logic             xfer
);

   localparam int PADC = DW - CTRL_W;
   localparam int PADV = DW - CW;

   if (DW < CTRL_W) begin : g_bad_dw
      $error("pwm_reg_bank: DW must hold the control word");
   end
   if (CW > DW) begin : g_bad_cw
      $error("pwm_reg_bank: CW must not exceed DW");
   end

   logic [CW-1:0] held_duty;
   logic          seen_zero;
   logic          arm_set;
   reg_addr_e     ra;

   assign ra      = reg_addr_e'(addr);
   assign arm_set = wr && (ra == RA_ARM) && wdata[0] && seen_zero;
   assign xfer    = reload_pt && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl      <= '0;
         held_mod  <= CW'(RST_MOD);
         held_duty <= '0;
         work_psc  <= '0;
         work_mod  <= CW'(RST_MOD);
         work_duty <= '0;
         armed     <= 1'b0;
         seen_zero <= 1'b0;
      end else begin
         if (wr) begin
            case (ra)
               RA_CTRL: ctrl      <= ctrl_t'(wdata[CTRL_W-1:0]);
               RA_MOD:  held_mod  <= wdata[CW-1:0];
               RA_DUTY: held_duty <= wdata[CW-1:0];
               default: ;
            endcase
         end
         if (rd && (ra == RA_ARM))
            seen_zero <= !armed;
         else if (wr && (ra == RA_ARM))
            seen_zero <= 1'b0;
         if (arm_set)
            armed <= 1'b1;
         else if (xfer)
            armed <= 1'b0;
         if (xfer) begin
            work_psc  <= ctrl.psc;
            work_mod  <= held_mod;
            work_duty <= held_duty;
         end
      end
   end

   always_comb begin
      case (ra)
         RA_CTRL: rdata = {{PADC{1'b0}}, ctrl};
         RA_MOD:  rdata = {{PADV{1'b0}}, held_mod};
         RA_DUTY: rdata = {{PADV{1'b0}}, held_duty};
         default: rdata = {{(DW-1){1'b0}}, armed};
      endcase
   end

   AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_pt && armed && !arm_set) |=> !armed); // R2
   AST_ARM_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(seen_zero)); // R3

endmodule

// File: rtl/pwm_reload_div.sv
module pwm_reload_div
   import pwm_reload_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             opp,
   input  logic [LDF_W-1:0] ldiv,
   output logic             reload_pt
);

   logic [LDF_W-1:0] opp_cnt;

   assign reload_pt = opp && (opp_cnt >= ldiv);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         opp_cnt <= '0;
      else if (reload_pt)
         opp_cnt <= '0;
      else if (opp)
         opp_cnt <= opp_cnt + 1'b1;
   end

   AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !opp |=> $stable(opp_cnt)); // R7

endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core
   import pwm_reload_pkg::*;
#(
   parameter int CW      = 8,
   parameter bit OUT_REG = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             center,
   input  logic             half,
   input  logic [PSC_W-1:0] work_psc,
   input  logic [CW-1:0]    work_mod,
   input  logic [CW-1:0]    work_duty,
   input  logic [CW-1:0]    new_mod,
   input  logic             reload_pt,
   input  logic             load,
   output logic             opp,
   output logic [CW-1:0]    cnt,
   output logic             pwm_out
);

   localparam int PCW = (1 << PSC_W) - 1;

   if (CW < 2) begin : g_bad_cw
      $error("pwm_count_core: CW must be at least 2");
   end

   logic [PCW-1:0] psc_cnt;
   logic [PCW-1:0] psc_mask;
   logic           tick;
   logic           up;
   logic           edge_wrap;
   logic           top_turn;
   logic           bot_turn;
   logic           below;

   assign psc_mask  = PCW'((1 << work_psc) - 1);
   assign tick      = (psc_cnt & psc_mask) == psc_mask;
   assign edge_wrap = tick && !center && (cnt >= work_mod - CW'(1));
   assign top_turn  = tick && center && up && (cnt >= work_mod);
   assign bot_turn  = tick && center && !up && (cnt <= CW'(1));
   assign opp       = edge_wrap || bot_turn || (top_turn && half);
   assign below     = cnt < work_duty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_cnt <= '0;
         cnt     <= '0;
         up      <= 1'b1;
      end else begin
         psc_cnt <= reload_pt ? '0 : psc_cnt + 1'b1;
         if (edge_wrap || bot_turn) begin
            cnt <= '0;
            up  <= 1'b1;
         end else if (top_turn) begin
            up  <= 1'b0;
            cnt <= load ? new_mod - CW'(1) : work_mod - CW'(1);
         end else if (tick) begin
            cnt <= (up || !center) ? cnt + 1'b1 : cnt - 1'b1;
         end
      end
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pwm_out <= 1'b0;
         else        pwm_out <= below;
      end
   end else begin : g_out_comb
      assign pwm_out = below;
      AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         (work_duty == '0) |-> !pwm_out); // R5
   end

   AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt)); // R4
   AST_HALF_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
      (top_turn && load) |=> (cnt == $past(new_mod) - CW'(1))); // R9
   AST_EDGE_NO_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (!center && opp) |-> (cnt >= work_mod - CW'(1))); // R10

endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
   import pwm_reload_pkg::*;
#(
   parameter int DW      = 16,
   parameter int CW      = 8,
   parameter int RST_MOD = 16,
   parameter bit OUT_REG = 1'b0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [1:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic [CW-1:0] count,
   output logic          pwm_out,
   output logic          reload_strobe,
   output logic          load_ok
);

   if (RST_MOD < 2 || RST_MOD >= (1 << CW)) begin : g_bad_mod
      $error("pwm_reload_ctrl: RST_MOD out of range for CW");
   end

   ctrl_t            ctrl;
   logic [CW-1:0]    held_mod;
   logic [PSC_W-1:0] work_psc;
   logic [CW-1:0]    work_mod;
   logic [CW-1:0]    work_duty;
   logic             armed;
   logic             xfer;
   logic             opp;
   logic             reload_pt;

   pwm_reg_bank #(.DW(DW), .CW(CW), .RST_MOD(RST_MOD)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .rd        (reg_rd),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .reload_pt (reload_pt),
      .ctrl      (ctrl),
      .held_mod  (held_mod),
      .work_psc  (work_psc),
      .work_mod  (work_mod),
      .work_duty (work_duty),
      .armed     (armed),
      .xfer      (xfer)
   );

   pwm_reload_div u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .opp       (opp),
      .ldiv      (ctrl.ldiv),
      .reload_pt (reload_pt)
   );

   pwm_count_core #(.CW(CW), .OUT_REG(OUT_REG)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .center    (ctrl.center),
      .half      (ctrl.half),
      .work_psc  (work_psc),
      .work_mod  (work_mod),
      .work_duty (work_duty),
      .new_mod   (held_mod),
      .reload_pt (reload_pt),
      .load      (xfer),
      .opp       (opp),
      .cnt       (count),
      .pwm_out   (pwm_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reload_strobe <= 1'b0;
      else        reload_strobe <= reload_pt;
   end

   assign load_ok = armed;

endmodule

// File: tb/pwm_reload_ctrl_test.sv
module pwm_reload_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [7:0]  count;
   logic        pwm_out;
   logic        reload_strobe;
   logic        load_ok;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   pwm_reload_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .count(count), .pwm_out(pwm_out), .reload_strobe(reload_strobe),
      .load_ok(load_ok)
   );

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 16'(d);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      reg_rd = 1'b1; reg_addr = 2'(a);
      #1 d = int'(reg_rdata);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   function automatic int ctrl_word(input int c, input int h, input int l, input int p);
      return (c << 7) | (h << 6) | (l << 2) | p;
   endfunction

   task automatic apply_cfg(input int c, input int h, input int l, input int p,
                            input int m, input int v);
      int d;
      wr(0, ctrl_word(c, h, l, p));
      wr(1, m);
      wr(2, v);
      rd(3, d);
      wr(3, 1);
      while (!(reload_strobe && !load_ok)) @(negedge clk);
   endtask

   task automatic measure(output int n, output int hi);
      n = 0; hi = 0;
      do begin
         hi += int'(pwm_out);
         n++;
         @(negedge clk);
      end while (!reload_strobe);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", 150000);
      finish_run();
   end

   initial begin
      int d, n, hi, m, v, ev, prev;
      repeat (3) @(negedge clk);
      // R1 reset state
      reg_addr = 2'd1;
      #1;
      check(count == 0, "R1 count", int'(count), 0);
      check(!load_ok && !reload_strobe && !pwm_out, "R1 flags", int'(load_ok), 0);
      check(reg_rdata == 16, "R1 modulus reset", int'(reg_rdata), 16);
      reg_addr = 2'd0;
      #1;
      check(reg_rdata == 0, "R1 control reset", int'(reg_rdata), 0);
      @(negedge clk);
      rst_n = 1'b1;
      // R8 first reload after L+1 = 4 opportunities of 16 clocks
      wr(0, ctrl_word(0, 0, 3, 0));
      while (!reload_strobe) @(negedge clk);
      check(cyc == 64, "R8 first strobe", cyc, 64);

      // R3 arming rules
      wr(3, 1);
      check(!load_ok, "R3 write without read", int'(load_ok), 0);
      rd(3, d);
      check(d == 0, "R3 read zero", d, 0);
      wr(3, 0);
      wr(3, 1);
      check(!load_ok, "R3 permission consumed", int'(load_ok), 0);
      rd(3, d);
      wr(3, 1);
      check(load_ok, "R3 armed", int'(load_ok), 1);
      while (!reload_strobe) @(negedge clk);
      check(!load_ok, "R2 flag cleared at reload", int'(load_ok), 0);

      // R5 R4 R7 R2 edge-aligned sweep
      for (int p = 0; p < 4; p++)
         for (int mi = 0; mi < 2; mi++)
            for (int vi = 0; vi < 3; vi++)
               for (int li = 0; li < 2; li++) begin
                  m = mi ? 5 : 3;
                  v = (vi == 0) ? 0 : (vi == 1) ? 2 : m;
                  apply_cfg(0, 0, li * 2, p, m, v);
                  measure(n, hi);
                  ev = (li * 2 + 1) * m * (1 << p);
                  check(n == ev, "R5 edge period", n, ev);
                  ev = (li * 2 + 1) * v * (1 << p);
                  check(hi == ev, "R4 edge duty", hi, ev);
               end

      // R7 divider keeps running while unarmed; held modulus stays unused
      apply_cfg(0, 0, 1, 0, 5, 2);
      wr(1, 9);
      while (!reload_strobe) @(negedge clk);
      measure(n, hi);
      check(n == 10, "R7 unarmed reload", n, 10);
      check(!load_ok && hi == 4, "R7 unarmed duty", hi, 4);

      // R6 center-aligned sweep
      for (int p = 0; p < 4; p += 2)
         for (int mi = 0; mi < 2; mi++)
            for (int vi = 0; vi < 3; vi++)
               for (int li = 0; li < 2; li++) begin
                  m = mi ? 6 : 3;
                  v = (vi == 0) ? 0 : (vi == 1) ? 1 : 3;
                  apply_cfg(1, 0, li, p, m, v);
                  measure(n, hi);
                  ev = (li + 1) * 2 * m * (1 << p);
                  check(n == ev, "R6 center period", n, ev);
                  ev = (v == 0) ? 0 : (li + 1) * (2 * v - 1) * (1 << p);
                  check(hi == ev, "R6 center duty", hi, ev);
               end

      // R9 half-cycle opportunities, L odd so spans hold whole periods
      for (int p = 0; p < 2; p++)
         for (int l = 1; l < 4; l += 2) begin
            apply_cfg(1, 1, l, p, 4, 2);
            measure(n, hi);
            ev = ((l + 1) / 2) * 8 * (1 << p);
            check(n == ev, "R9 half period", n, ev);
            ev = ((l + 1) / 2) * 3 * (1 << p);
            check(hi == ev, "R9 half duty", hi, ev);
         end

      // R10 half bit ignored in edge mode
      apply_cfg(0, 1, 0, 0, 6, 2);
      measure(n, hi);
      check(n == 6, "R10 edge with half bit", n, 6);

      // R9 snap to new modulus minus one at the top
      apply_cfg(1, 1, 0, 0, 8, 3);
      wr(1, 5);
      while (!(reload_strobe && count == 0)) @(negedge clk);
      rd(3, d);
      wr(3, 1);
      prev = int'(count);
      while (!reload_strobe) begin
         prev = int'(count);
         @(negedge clk);
      end
      check(prev == 8, "R9 top before snap", prev, 8);
      check(count == 4, "R9 snap count", int'(count), 4);
      measure(n, hi);
      check(n == 4, "R9 down run after snap", n, 4);
      check(!load_ok, "R2 flag after snap", int'(load_ok), 0);

      finish_run();
   end

endmodule